// File: doc/BRIEF.md
# Block Erase Sequencer

This block carries out the internal erase of one array block once an erase has been confirmed. A start pulse comes with any address that falls inside the target block. The block base is that address with its low offset bits cleared. The block is always treated as a whole, and no single word is ever erased on its own.

The sequence has four phases. First it writes 0 to every word of the block. Next it reads each word back and checks that it holds 0. Then it fires one bulk-erase pulse over the whole block. Last it reads every word back and checks that it holds all 1s. When a check fails, the sequencer repairs the fault and tries again: in the zero check it rewrites the failing word, and in the ones check it fires a new erase pulse. The number of such retries in one check phase has an upper bound. Past that bound the sequencer reports a failure and stops.

A suspend request is taken at the next word boundary. While suspended, the block makes no array access and keeps its phase and word index. A resume pulse continues the sequence from exactly that point. The array port is a simple synchronous word memory. Read data is valid one cycle after the read strobe. The bulk-erase strobe acts on the block that contains `mem_addr`.

Top module: `erase_seq`

## Requirements
- R1: On an accepted `start`, the block base is `start_addr` with its low log2(BLK_WORDS) bits cleared. Every array access and erase pulse of that operation addresses a word whose upper bits equal the upper bits of that base.
- R2: The program phase writes the value 0 once to each word of the block, in ascending address order from the base. This happens before any read is issued.
- R3: The zero-check phase reads each word in ascending order. A word that does not read back as 0 is written with 0 again and read again before the check moves on to the next word.
- R4: The erase pulse is issued only after every word of the block has passed the zero check. With no faults, exactly one pulse is issued.
- R5: After the erase pulse, each word is read in ascending order and must read all 1s. A mismatch causes another erase pulse, and the check then continues from the same word.
- R6: Each check phase allows at most MAX_RETRY mismatches. The next mismatch after that ends the operation with `fail`=1 and no further array accesses. For a phase with k mismatches in total, the number of extra writes (zero check) or extra pulses (ones check) is min(k, MAX_RETRY).
- R7: A `suspend_req` held high is taken before the next word step, which is a write, a read issue or an erase pulse. From then on `suspended`=1, `busy`=1, and `mem_we`, `mem_re` and `erase_pulse` stay 0.
- R8: The block leaves suspension only on `resume_req`. It then continues in the same phase and at the same word index, so no word is skipped or visited twice.
- R9: A `start` that arrives while `busy`=1 is ignored, and the operation in progress keeps its block.
- R10: When the operation ends, `done` is high for exactly one cycle. In that same cycle `busy` is 0. `fail` keeps its value until the next accepted `start`, which clears it.
- R11: After reset, `busy`, `suspended`, `done`, `fail`, `mem_we`, `mem_re` and `erase_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse for an erase, taken only when idle |
| start_addr | input | ADDR_W | Any address inside the target block |
| suspend_req | input | 1 | Level request to pause at the next word boundary |
| resume_req | input | 1 | Pulse that continues a suspended erase |
| mem_addr | output | ADDR_W | Array word address |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | DATA_W | Array write data, always 0 |
| mem_re | output | 1 | Array read strobe, data expected on the next cycle |
| mem_rdata | input | DATA_W | Array read data |
| erase_pulse | output | 1 | Bulk-erase strobe for the block that holds mem_addr |
| busy | output | 1 | An operation is in progress, including while suspended |
| suspended | output | 1 | The sequencer is parked at a word boundary |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | The last operation ran out of retries |

## Verification
The bench builds the block with BLK_WORDS=16, ADDR_W=10 and MAX_RETRY=2. With those values a whole erase takes about a hundred cycles, so many runs fit in the time allowed. A retry bound of 2 means three injected faults on one word reach the exact point where a pass turns into a fail, in both check phases. The array model can refuse a write of 0, or refuse an erase pulse, a chosen number of times. This exercises retry counts on both sides of the bound, together with suspends at random points and restarts into other blocks.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_RD0,
    ST_CMP0,
    ST_ERASE,
    ST_RD1,
    ST_CMP1,
    ST_SUSP
  } seq_st_t;
endpackage

// File: rtl/erase_word_ctr.sv
module erase_word_ctr #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (inc) idx <= idx + 1'b1;
  end

  assign last = (idx == {IDX_W{1'b1}});

  // R2: the index never wraps on an increment
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !last);
endmodule

// File: rtl/erase_retry_ctr.sv
module erase_retry_ctr #(
  parameter int MAX_RETRY = 3,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_max = (cnt == CNT_W'(MAX_RETRY));

  // R6: the retry count stays within its bound
  a_r6_retry_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_RETRY));
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int BLK_WORDS = 64,
  parameter int MAX_RETRY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              suspend_req,
  input  logic              resume_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              erase_pulse,
  output logic              busy,
  output logic              suspended,
  output logic              done,
  output logic              fail
);
  localparam int OFF_W = $clog2(BLK_WORDS);
  localparam int RTY_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  function automatic logic [ADDR_W-1:0] blk_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [OFF_W-1:0]  off);
    return {base[ADDR_W-1:OFF_W], off};
  endfunction

  function automatic logic is_all(input logic [DATA_W-1:0] d, input logic b);
    return d == {DATA_W{b}};
  endfunction

  seq_st_t           st_q, nxt, ret_q;
  logic [ADDR_W-1:0] base_q;
  logic              fix_q, fail_q, done_q, zero_ok_q;
  logic [OFF_W-1:0]  idx;
  logic              last;
  logic [RTY_W-1:0]  rcnt;
  logic              r_at_max;
  logic              idx_clr, idx_inc, r_clr, r_inc;
  logic              set_fix, clr_fix, set_zok, go_fail, go_done, accept;

  // named events used by the assertions
  logic at_boundary, take_susp, rd_match;

  assign at_boundary = (st_q == ST_PROG) || (st_q == ST_RD0) ||
                       (st_q == ST_ERASE) || (st_q == ST_RD1);
  assign take_susp   = at_boundary && suspend_req;
  assign rd_match    = is_all(mem_rdata, st_q == ST_CMP1);
  assign accept      = (st_q == ST_IDLE) && start;

  erase_word_ctr #(.IDX_W(OFF_W)) u_word (
    .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc),
    .idx(idx), .last(last));

  erase_retry_ctr #(.MAX_RETRY(MAX_RETRY), .CNT_W(RTY_W)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr(r_clr), .inc(r_inc),
    .cnt(rcnt), .at_max(r_at_max));

  always_comb begin
    nxt = st_q;
    idx_clr = 1'b0; idx_inc = 1'b0; r_clr = 1'b0; r_inc = 1'b0;
    set_fix = 1'b0; clr_fix = 1'b0; set_zok = 1'b0;
    go_fail = 1'b0; go_done = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin nxt = ST_PROG; idx_clr = 1'b1; r_clr = 1'b1; end
      ST_PROG: begin
        if (take_susp)  nxt = ST_SUSP;
        else if (fix_q) begin nxt = ST_RD0; clr_fix = 1'b1; end
        else if (last)  begin nxt = ST_RD0; idx_clr = 1'b1; end
        else            idx_inc = 1'b1;
      end
      ST_RD0:  nxt = take_susp ? ST_SUSP : ST_CMP0;
      ST_CMP0: begin
        if (rd_match) begin
          if (last) begin
            nxt = ST_ERASE; idx_clr = 1'b1; r_clr = 1'b1; set_zok = 1'b1;
          end else begin
            nxt = ST_RD0; idx_inc = 1'b1;
          end
        end else if (r_at_max) begin
          nxt = ST_IDLE; go_fail = 1'b1;
        end else begin
          nxt = ST_PROG; r_inc = 1'b1; set_fix = 1'b1;
        end
      end
      ST_ERASE: nxt = take_susp ? ST_SUSP : ST_RD1;
      ST_RD1:   nxt = take_susp ? ST_SUSP : ST_CMP1;
      ST_CMP1: begin
        if (rd_match) begin
          if (last) begin nxt = ST_IDLE; go_done = 1'b1; end
          else begin nxt = ST_RD1; idx_inc = 1'b1; end
        end else if (r_at_max) begin
          nxt = ST_IDLE; go_fail = 1'b1;
        end else begin
          nxt = ST_ERASE; r_inc = 1'b1;
        end
      end
      ST_SUSP: if (resume_req) nxt = ret_q;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ret_q     <= ST_IDLE;
      base_q    <= '0;
      fix_q     <= 1'b0;
      fail_q    <= 1'b0;
      done_q    <= 1'b0;
      zero_ok_q <= 1'b0;
    end else begin
      st_q   <= nxt;
      done_q <= go_done || go_fail;
      if (take_susp) ret_q <= st_q;
      if (accept) begin
        base_q    <= blk_base(start_addr);
        fail_q    <= 1'b0;
        zero_ok_q <= 1'b0;
        fix_q     <= 1'b0;
      end else begin
        if (go_fail) fail_q    <= 1'b1;
        if (set_zok) zero_ok_q <= 1'b1;
        if (set_fix)      fix_q <= 1'b1;
        else if (clr_fix) fix_q <= 1'b0;
      end
    end
  end

  assign mem_addr    = word_addr(base_q, idx);
  assign mem_wdata   = '0;
  assign mem_we      = (st_q == ST_PROG) && !suspend_req;
  assign mem_re      = ((st_q == ST_RD0) || (st_q == ST_RD1)) && !suspend_req;
  assign erase_pulse = (st_q == ST_ERASE) && !suspend_req;
  assign busy        = (st_q != ST_IDLE);
  assign suspended   = (st_q == ST_SUSP);
  assign done        = done_q;
  assign fail        = fail_q;

  // R7: no array activity while parked
  a_r7_quiet_when_susp: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!mem_we && !mem_re && !erase_pulse && busy));

  // R8: parked state is left only through a resume
  a_r8_stay_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !resume_req) |=> suspended);

  // R4: the erase strobe follows a fully passed zero check
  a_r4_erase_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |-> zero_ok_q);

  // R1: accesses stay inside the selected block
  a_r1_same_block: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re || erase_pulse) |->
      (mem_addr[ADDR_W-1:OFF_W] == base_q[ADDR_W-1:OFF_W]));

  // R9: a start during an operation leaves the block unchanged
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(base_q));

  // R10: completion is a single-cycle pulse, with busy already low
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !suspended) ##1 !done);

  // R6: a failure is reported together with completion
  a_r6_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);
endmodule

// File: tb/erase_seq_tb.sv
module erase_seq_tb;
  localparam int CLK_NS = 10;
  localparam int AW     = 10;
  localparam int DW     = 16;
  localparam int BLK    = 16;
  localparam int MAXR   = 2;
  localparam int DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          suspend_req = 1'b0;
  logic          resume_req = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re, erase_pulse, busy, suspended, done, fail;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  erase_seq #(.ADDR_W(AW), .DATA_W(DW), .BLK_WORDS(BLK), .MAX_RETRY(MAXR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .suspend_req(suspend_req), .resume_req(resume_req),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .erase_pulse(erase_pulse),
    .busy(busy), .suspended(suspended), .done(done), .fail(fail));

  // array model with injectable faults
  logic [DW-1:0] mem    [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  logic [AW-1:0] wr_log [64];
  int wr_n, pulses, acc_n, zf_left, ef_left;
  logic [AW-1:0] fz_addr, fe_addr;

  always @(posedge clk) begin
    if (mem_we || mem_re || erase_pulse) acc_n <= acc_n + 1;
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (mem_we) begin
      if (wr_n < 64) wr_log[wr_n] <= mem_addr;
      wr_n <= wr_n + 1;
      if (zf_left > 0 && mem_addr == fz_addr && mem_wdata == '0) zf_left <= zf_left - 1;
      else mem[mem_addr] <= mem_wdata;
    end
    if (erase_pulse) begin
      pulses <= pulses + 1;
      for (int i = 0; i < BLK; i++) begin
        if (ef_left > 0 && {mem_addr[AW-1:$clog2(BLK)], 4'(i)} == fe_addr) ;
        else mem[{mem_addr[AW-1:$clog2(BLK)], 4'(i)}] <= '1;
      end
      if (ef_left > 0) ef_left <= ef_left - 1;
    end
  end

  function automatic logic [AW-1:0] exp_base(input logic [AW-1:0] a);
    return a & ~AW'(BLK - 1);
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] addr, input int zf, input int ef,
                     input bit sus, input bit restart);
    logic [AW-1:0] base;
    int cyc, k, acc0, sat, diffs, ones, order_bad, blk_bad;
    bit exp_fail;
    base = exp_base(addr);
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'($urandom) | 16'h0001;
      shadow[i] = mem[i];
    end
    fz_addr = base + AW'($urandom % BLK);
    fe_addr = base + AW'($urandom % BLK);
    zf_left = zf; ef_left = ef;
    wr_n = 0; pulses = 0; acc_n = 0;
    exp_fail = (zf > MAXR) || (ef > MAXR);
    sat = 2 + int'($urandom % (BLK - 2));
    @(negedge clk);
    start = 1'b1; start_addr = addr;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 4000) begin
      if (restart && cyc == 5) begin
        start = 1'b1; start_addr = addr ^ AW'(BLK * 3);
        @(negedge clk);
        start = 1'b0;
      end
      if (sus && cyc == sat) begin
        suspend_req = 1'b1;
        k = 0;
        while (!suspended && k < 6) begin @(negedge clk); k++; end
        check(suspended == 1'b1, "R7 suspend taken", suspended, 1);
        acc0 = acc_n;
        repeat (4) @(negedge clk);
        check(acc_n == acc0 && busy, "R7 no access while suspended", acc_n - acc0, 0);
        suspend_req = 1'b0;
        @(negedge clk);
        check(suspended == 1'b1, "R8 held until resume", suspended, 1);
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
        check(suspended == 1'b0, "R8 resumed", suspended, 0);
      end
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1 && busy == 1'b0, "R10 done with busy low", {done, busy}, 2);
    check(fail == exp_fail, "R6 fail outcome", fail, exp_fail);
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
    check(fail == exp_fail, "R10 fail held", fail, exp_fail);
    check(wr_n == BLK + min2(zf, MAXR), "R3 write count", wr_n, BLK + min2(zf, MAXR));
    check(pulses == ((zf > MAXR) ? 0 : 1 + min2(ef, MAXR)), "R5 erase pulse count",
          pulses, (zf > MAXR) ? 0 : 1 + min2(ef, MAXR));
    order_bad = 0; blk_bad = 0;
    for (int i = 0; i < wr_n && i < 64; i++)
      if (exp_base(wr_log[i]) != base) blk_bad++;
    for (int i = 0; i < BLK && i < wr_n; i++)
      if (zf == 0 && wr_log[i] != base + AW'(i)) order_bad++;
    check(blk_bad == 0, "R1 writes inside block", blk_bad, 0);
    check(order_bad == 0, "R2 R8 ascending writes once each", order_bad, 0);
    diffs = 0; ones = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (exp_base(AW'(i)) == base) begin
        if (mem[i] == '1) ones++;
      end else if (mem[i] != shadow[i]) diffs++;
    end
    check(diffs == 0, "R9 other blocks untouched", diffs, 0);
    if (!exp_fail) check(ones == BLK, "R5 block all ones", ones, BLK);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check(!busy && !suspended && !done && !fail, "R11 reset outputs",
          {busy, suspended, done, fail}, 0);
    check(!mem_we && !mem_re && !erase_pulse, "R11 reset strobes",
          {mem_we, mem_re, erase_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(10'h123, 0, 0, 1'b0, 1'b0);           // R1 R2 R4 plain erase
    run(10'h2F0, MAXR, 0, 1'b0, 1'b0);        // R3 retries at the bound pass
    run(10'h047, MAXR + 1, 0, 1'b0, 1'b0);    // R6 zero check exhausted
    run(10'h3A5, 0, MAXR, 1'b0, 1'b0);        // R5 extra pulses pass
    run(10'h19C, 0, MAXR + 1, 1'b0, 1'b0);    // R6 ones check exhausted
    run(10'h0FF, 0, 0, 1'b1, 1'b0);           // R7 R8 suspend and resume
    run(10'h26B, 0, 0, 1'b0, 1'b1);           // R9 start while busy
    run(10'h311, 0, 0, 1'b0, 1'b0);           // R10 fail cleared by new start
    for (int n = 0; n < 10; n++) begin
      int zf, ef;
      zf = ($urandom % 3 == 0) ? int'($urandom % (MAXR + 2)) : 0;
      ef = int'($urandom % (MAXR + 2));
      run(AW'($urandom), zf, ef, 1'($urandom), 1'($urandom));
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule